// File: doc/BRIEF.md
# Shared Register File with Host-Priority Write Arbitration

This block is a bank of 8-bit registers shared between a host CPU and an I/O processor. Each side has its own address, write-data and read-data lines. Each side can read every location at any time, and reads return data in the same cycle the address is presented. A parameterised write-permission bitmap for each port sets which locations that side may change. A write to a location outside its port's bitmap is dropped without any indication.

Both ports may write the same location in the same clock cycle, provided each write is permitted. In that case the host value is stored and the processor value is lost. A one-bit collision indicator is then raised on the processor side. The processor has to inspect it right after the write, because the indicator is recomputed on its next access.

Top module: `arb_regfile`

## Requirements
- R1: After reset every location reads 0x00 on both ports, and `iop_flag_o` reads 0x00.
- R2: A host write (`host_wr_i`=1) to a location whose bit is set in `HOST_WMASK` stores `host_wdata_i` at that clock edge. The default mask allows locations 0 to 63.
- R3: A processor write (`iop_req_i`=1, `iop_we_i`=1) to a location whose bit is set in `IOP_WMASK` stores `iop_wdata_i` at that clock edge. The default mask allows locations 32 to 127.
- R4: A write to a location outside the writing port's mask leaves that location unchanged.
- R5: Both read ports return the current contents of any location combinationally, with no cycle of latency.
- R6: When permitted host and processor writes target the same location in the same cycle, the host data is stored. If only one of the two writes is permitted, that write is stored and no collision is counted.
- R7: After a collision, `iop_flag_o` reads 0x01. Bit 0 is the collision bit, and bits 7 to 1 always read zero.
- R8: Each processor access (`iop_req_i`=1, read or write) that does not collide clears the collision bit at that edge. Cycles without a processor access leave the bit unchanged.
- R9: Permitted writes from both ports to different locations in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | ADDR_W | Host address |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data (combinational) |
| iop_addr_i | input | ADDR_W | Processor address |
| iop_req_i | input | 1 | Processor access strobe |
| iop_we_i | input | 1 | Processor write select, qualified by `iop_req_i` |
| iop_wdata_i | input | DATA_W | Processor write data |
| iop_rdata_o | output | DATA_W | Processor read data (combinational) |
| iop_flag_o | output | DATA_W | Processor status; bit 0 is the collision bit |

## Verification
Single-port writes to the edges of each mask show whether the permission maps are decoded with the correct bit ordering. Simultaneous writes are applied in three forms:
- to the same permitted location, which shows whether host priority is applied and the flag is raised;
- to a location that only one side may write, which shows a permitted write is not mistaken for a collision;
- to different locations, which shows two independent writes are not suppressed as a collision.

After a collision, the bench runs host-only cycles and then a processor read. This separates a flag that holds until the next processor access from one that clears on any cycle.

// File: rtl/arb_regfile_pkg.sv
package arb_regfile_pkg;

  // Per-cycle write arbitration result
  typedef struct packed {
    logic host_ok;
    logic iop_ok;
    logic collide;
  } wr_arb_t;

endpackage

// File: rtl/arb_regfile_wr_ctrl.sv
module arb_regfile_wr_ctrl
  import arb_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH-1:0] HOST_WMASK = '1,
  parameter logic [DEPTH-1:0] IOP_WMASK  = '1
) (
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] iop_addr_i,
  input  logic              iop_req_i,
  input  logic              iop_we_i,
  output wr_arb_t           arb_o
);

  logic host_perm, iop_perm;

  assign host_perm = HOST_WMASK[host_addr_i];
  assign iop_perm  = IOP_WMASK[iop_addr_i];

  always_comb begin
    arb_o.host_ok = host_wr_i & host_perm;
    arb_o.iop_ok  = iop_req_i & iop_we_i & iop_perm;
    arb_o.collide = arb_o.host_ok & arb_o.iop_ok & (host_addr_i == iop_addr_i);
  end

endmodule

// File: rtl/arb_regfile_store.sv
module arb_regfile_store #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          host_we_i,
  input  logic [ADDR_W-1:0]             host_addr_i,
  input  logic [DATA_W-1:0]             host_wdata_i,
  input  logic                          iop_we_i,
  input  logic [ADDR_W-1:0]             iop_addr_i,
  input  logic [DATA_W-1:0]             iop_wdata_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  mem_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    logic host_hit, iop_hit;
    assign host_hit = host_we_i && (host_addr_i == ADDR_W'(i));
    assign iop_hit  = iop_we_i  && (iop_addr_i  == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mem_o[i] <= '0;
      else if (host_hit) mem_o[i] <= host_wdata_i;  // host wins on overlap
      else if (iop_hit)  mem_o[i] <= iop_wdata_i;
    end
  end

endmodule

// File: rtl/arb_regfile_flag.sv
module arb_regfile_flag #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iop_req_i,
  input  logic              collide_i,
  output logic [DATA_W-1:0] flag_o
);

  logic coll_q;

  // Recomputed on every processor access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        coll_q <= 1'b0;
    else if (iop_req_i) coll_q <= collide_i;
  end

  assign flag_o = {{(DATA_W-1){1'b0}}, coll_q};

endmodule

// File: rtl/arb_regfile.sv
module arb_regfile
  import arb_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH-1:0] HOST_WMASK = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
  parameter logic [DEPTH-1:0] IOP_WMASK  = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic [ADDR_W-1:0] iop_addr_i,
  input  logic              iop_req_i,
  input  logic              iop_we_i,
  input  logic [DATA_W-1:0] iop_wdata_i,
  output logic [DATA_W-1:0] iop_rdata_o,
  output logic [DATA_W-1:0] iop_flag_o
);

  wr_arb_t                       arb;
  logic [DEPTH-1:0][DATA_W-1:0]  mem;

  arb_regfile_wr_ctrl #(
    .ADDR_W     (ADDR_W),
    .HOST_WMASK (HOST_WMASK),
    .IOP_WMASK  (IOP_WMASK)
  ) u_wr_ctrl (
    .host_addr_i (host_addr_i),
    .host_wr_i   (host_wr_i),
    .iop_addr_i  (iop_addr_i),
    .iop_req_i   (iop_req_i),
    .iop_we_i    (iop_we_i),
    .arb_o       (arb)
  );

  arb_regfile_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (arb.host_ok),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .iop_we_i     (arb.iop_ok),
    .iop_addr_i   (iop_addr_i),
    .iop_wdata_i  (iop_wdata_i),
    .mem_o        (mem)
  );

  arb_regfile_flag #(
    .DATA_W (DATA_W)
  ) u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .iop_req_i (iop_req_i),
    .collide_i (arb.collide),
    .flag_o    (iop_flag_o)
  );

  assign host_rdata_o = mem[host_addr_i];
  assign iop_rdata_o  = mem[iop_addr_i];

endmodule

// File: rtl/arb_regfile_chk.sv
module arb_regfile_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH-1:0] HOST_WMASK = '1,
  parameter logic [DEPTH-1:0] IOP_WMASK  = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_wr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic [ADDR_W-1:0] iop_addr_i,
  input logic              iop_req_i,
  input logic              iop_we_i,
  input logic [DATA_W-1:0] iop_rdata_o,
  input logic [DATA_W-1:0] iop_flag_o
);

  logic h_ok, i_ok, same, coll;
  assign h_ok = host_wr_i && HOST_WMASK[host_addr_i];
  assign i_ok = iop_req_i && iop_we_i && IOP_WMASK[iop_addr_i];
  assign same = (host_addr_i == iop_addr_i);
  assign coll = h_ok && i_ok && same;

  // R6
  host_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll |=> (iop_addr_i != $past(iop_addr_i)) || (iop_rdata_o == $past(host_wdata_i)));

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll |=> iop_flag_o == DATA_W'(1));

  // R7
  flag_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iop_flag_o[DATA_W-1:1] == '0);

  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iop_req_i && !coll) |=> iop_flag_o == '0);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iop_req_i |=> $stable(iop_flag_o));

  // R4
  host_denied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !HOST_WMASK[host_addr_i] && !(i_ok && same))
    |=> (host_addr_i != $past(host_addr_i)) || (host_rdata_o == $past(host_rdata_o)));

  // R4
  iop_denied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iop_req_i && iop_we_i && !IOP_WMASK[iop_addr_i] && !(h_ok && same))
    |=> (iop_addr_i != $past(iop_addr_i)) || (iop_rdata_o == $past(iop_rdata_o)));

endmodule

bind arb_regfile arb_regfile_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .HOST_WMASK (HOST_WMASK),
  .IOP_WMASK  (IOP_WMASK)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_addr_i  (host_addr_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .iop_addr_i   (iop_addr_i),
  .iop_req_i    (iop_req_i),
  .iop_we_i     (iop_we_i),
  .iop_rdata_o  (iop_rdata_o),
  .iop_flag_o   (iop_flag_o)
);

// File: tb/arb_regfile_bench.sv
`timescale 1ns/1ps
module arb_regfile_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] host_addr_i = '0;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic [6:0] iop_addr_i = '0;
  logic       iop_req_i = 1'b0;
  logic       iop_we_i = 1'b0;
  logic [7:0] iop_wdata_i = '0;
  logic [7:0] iop_rdata_o;
  logic [7:0] iop_flag_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  arb_regfile u_arb_regfile (
    .clk_i, .rst_ni,
    .host_addr_i, .host_wr_i, .host_wdata_i, .host_rdata_o,
    .iop_addr_i, .iop_req_i, .iop_we_i, .iop_wdata_i, .iop_rdata_o, .iop_flag_o
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // One clock with the given strobes, released after the edge
  task automatic cycle(logic hw, logic [6:0] ha, logic [7:0] hd,
                       logic ir, logic iw, logic [6:0] ia, logic [7:0] id);
    @(negedge clk_i);
    host_wr_i = hw; host_addr_i = ha; host_wdata_i = hd;
    iop_req_i = ir; iop_we_i = iw; iop_addr_i = ia; iop_wdata_i = id;
    @(posedge clk_i); #1;
    host_wr_i = 1'b0; iop_req_i = 1'b0; iop_we_i = 1'b0;
  endtask

  task automatic rd_both(string req, logic [6:0] a, logic [7:0] exp);
    host_addr_i = a; iop_addr_i = a; #0.5;
    check({req, " host port"}, host_rdata_o, exp);
    check({req, " iop port"}, iop_rdata_o, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 128; a++) rd_both("R1", 7'(a), 8'h00);
    check("R1 flag", iop_flag_o, 8'h00);
  endtask

  task automatic t_host_wr();
    cycle(1, 7'd5, 8'hA5, 0, 0, 0, 0);
    rd_both("R2 R5 loc5", 7'd5, 8'hA5);
    cycle(1, 7'd63, 8'h3C, 0, 0, 0, 0);
    rd_both("R2 R5 loc63", 7'd63, 8'h3C);
  endtask

  task automatic t_iop_wr();
    cycle(0, 0, 0, 1, 1, 7'd32, 8'h11);
    rd_both("R3 R5 loc32", 7'd32, 8'h11);
    cycle(0, 0, 0, 1, 1, 7'd127, 8'h7E);
    rd_both("R3 R5 loc127", 7'd127, 8'h7E);
  endtask

  task automatic t_denied();
    cycle(1, 7'd64, 8'hFF, 0, 0, 0, 0);
    rd_both("R4 host loc64", 7'd64, 8'h00);
    cycle(0, 0, 0, 1, 1, 7'd31, 8'hFF);
    rd_both("R4 iop loc31", 7'd31, 8'h00);
    cycle(0, 0, 0, 1, 1, 7'd100, 8'h42);
    cycle(1, 7'd100, 8'h99, 0, 0, 0, 0);
    rd_both("R4 host keeps loc100", 7'd100, 8'h42);
    cycle(0, 0, 0, 1, 1, 7'd0, 8'h77);
    rd_both("R4 iop keeps loc0", 7'd0, 8'h00);
  endtask

  task automatic t_collide();
    cycle(1, 7'd40, 8'hAA, 1, 1, 7'd40, 8'h55);
    check("R7 flag set", iop_flag_o, 8'h01);
    rd_both("R6 host wins", 7'd40, 8'hAA);
    cycle(1, 7'd1, 8'h01, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    check("R8 flag held", iop_flag_o, 8'h01);
    cycle(0, 0, 0, 1, 0, 7'd40, 0);
    check("R8 flag cleared by read", iop_flag_o, 8'h00);
    cycle(1, 7'd50, 8'hC3, 1, 1, 7'd50, 8'h3C);
    check("R7 flag set again", iop_flag_o, 8'h01);
    rd_both("R6 host wins loc50", 7'd50, 8'hC3);
    cycle(0, 0, 0, 1, 1, 7'd51, 8'h5A);
    check("R8 flag cleared by write", iop_flag_o, 8'h00);
    rd_both("R3 loc51", 7'd51, 8'h5A);
  endtask

  task automatic t_half_permitted();
    cycle(1, 7'd45, 8'hE1, 1, 1, 7'd45, 8'hE2);
    check("R7 preset", iop_flag_o, 8'h01);
    cycle(1, 7'd10, 8'hD4, 1, 1, 7'd10, 8'h4D);
    check("R6 iop denied no collision", iop_flag_o, 8'h00);
    rd_both("R6 host value loc10", 7'd10, 8'hD4);
    cycle(1, 7'd100, 8'h13, 1, 1, 7'd100, 8'h31);
    check("R6 host denied no collision", iop_flag_o, 8'h00);
    rd_both("R6 iop value loc100", 7'd100, 8'h31);
  endtask

  task automatic t_diff_addr();
    cycle(1, 7'd20, 8'h21, 1, 1, 7'd90, 8'h90);
    check("R9 flag clear", iop_flag_o, 8'h00);
    rd_both("R9 host side loc20", 7'd20, 8'h21);
    rd_both("R9 iop side loc90", 7'd90, 8'h90);
    cycle(1, 7'd33, 8'hB1, 1, 1, 7'd34, 8'hB2);
    rd_both("R9 overlap zone loc33", 7'd33, 8'hB1);
    rd_both("R9 overlap zone loc34", 7'd34, 8'hB2);
  endtask

  initial begin
    #1;
    t_reset();
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    t_host_wr();
    t_iop_wr();
    t_denied();
    t_collide();
    t_half_permitted();
    t_diff_addr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule